// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers sixteen single-cycle event pulses into two 8-bit sticky status registers. Each status register has its own 8-bit enable register. Whenever a latched status bit has its matching enable bit set, the block drives a registered, active-low interrupt request line to the host. The host services the request over a plain synchronous register port. It drives an address, a write strobe with write data, and a read strobe, and the read data appears one cycle later.

Reading a status register returns its contents as they were before the read, and clears only the bits that are enabled. Events whose enable bit is 0 still latch and stay readable, but they never pull the request line low. They can be polled at any time. An event that lands in the same cycle as the read that clears its register is kept, so the next read reports it.

Register map (byte addresses): 03h is status A, fed by `evt_i[7:0]`. 04h is status B, fed by `evt_i[15:8]`. 05h is enable A and 06h is enable B, each enable bit at the same position as its status bit. In register A, bit positions 6, 5 and 2 are unused. In register B every position is used.

Top module: `irq_status_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_i[n]` sets a sticky status bit. Pulses on bits 7..0 land in status A (address 03h) and pulses on bits 15..8 land in bits 7..0 of status B (address 04h). Status registers are read-only: writes to 03h/04h change nothing.
- R2: Enable A (05h) and enable B (06h) are read/write. After reset, enable A reads 00h and enable B reads 01h.
- R3: In status A and enable A, bit positions 6, 5 and 2 always read 0. Writes to them are dropped, and events on `evt_i[6]`, `evt_i[5]` and `evt_i[2]` never latch. With all writes accepted, enable A reads 9Bh.
- R4: `irq_n_o` is 1 out of reset. It is registered: it goes low one clock after the clock edge at which some status bit and its enable bit are both 1.
- R5: An event whose enable bit is 0 latches into status but never drives `irq_n_o` low.
- R6: A read strobe returns the addressed register on `rd_data_o` one cycle later. For a status register, this is the value before the clear. The read clears only the bits of that register whose enable bit is 1, and disabled bits stay set.
- R7: A status read affects only the register addressed. `irq_n_o` returns high one clock after the read that clears the last pending enabled bit, and it stays low while the other register still has a pending enabled bit.
- R8: An event arriving in the same cycle as the clearing read of its register is not lost. The bit is set after the read, whether or not it was set before.
- R9: Writing an enable bit to 1 for a status bit that is already latched drives `irq_n_o` low one clock after the write.
- R10: Reads of addresses outside 03h..06h return 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 16 | Event pulses, bits 7..0 to status A, bits 15..8 to status B |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench goes after the clear-on-read corners:
- A disabled bit must survive a status read. A design that cleared every bit would report it only once.
- An event in the same cycle as the clearing read must survive. A design that let the clear win would drop that event silently.
- Reading one register must leave the other's pending bit alone. A design that failed this would release the request line too early.

The bench also checks request timing. It expects `irq_n_o` to fall exactly one cycle after the status or enable edge and not in the same cycle, which a combinational output would get wrong. It checks that writing an enable bit over an old latched event raises the request. It also probes the unused positions and out-of-range addresses, where a design without masking reads back garbage.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W     = 8;
  localparam int NREG      = 2;
  localparam int ADDR_W    = 8;
  localparam int EVT_W     = REG_W * NREG;
  localparam int STAT_BASE = 3;
  localparam int EN_BASE   = STAT_BASE + NREG;

  // positions that exist in each register
  function automatic logic [REG_W-1:0] valid_mask(input int idx);
    return (idx == 0) ? 8'h9B : 8'hFF;
  endfunction

  // enable value after reset
  function automatic logic [REG_W-1:0] en_reset(input int idx);
    return (idx == 0) ? 8'h00 : 8'h01;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int             W      = 8,
  parameter logic [W-1:0]   VALID  = '1,
  parameter logic [W-1:0]   EN_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] evt_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] evt_m, clr_m;
  logic         stat_ce, en_ce;

  always_comb begin
    evt_m   = evt_i & VALID;
    clr_m   = clr_i ? en_q : '0;
    // new events win over the clear
    stat_d  = (stat_q & ~clr_m) | evt_m;
    stat_ce = clr_i | (|evt_m);
    en_d    = wr_data_i & VALID;
    en_ce   = wr_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   en_q <= EN_RST;
    else if (en_ce) en_q <= en_d;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((stat_q | en_q) & ~VALID) == '0);

  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_clear_only_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> ((stat_q & $past(stat_q & ~en_q)) == $past(stat_q & ~en_q)));

  assert_event_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> ((stat_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] pend_i,
  output logic         irq_n_o
);
  logic irq_n_q, irq_n_d;

  always_comb irq_n_d = ~(|pend_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) irq_n_q <= 1'b1;
    else          irq_n_q <= irq_n_d;
  end

  assign irq_n_o = irq_n_q;

  assert_irq_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> (irq_n_o == !$past(|pend_i)));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_n_o
);
  logic             rst_n;
  logic [REG_W-1:0] stat [NREG];
  logic [REG_W-1:0] en   [NREG];
  logic [NREG-1:0]  pend;
  logic [NREG-1:0]  sel_stat, sel_en;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rd_q;
  logic             in_range;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign sel_stat[g] = (addr_i == ADDR_W'(STAT_BASE + g));
    assign sel_en[g]   = (addr_i == ADDR_W'(EN_BASE + g));

    irq_stat_bank #(
      .W(REG_W), .VALID(valid_mask(g)), .EN_RST(en_reset(g))
    ) u_bank (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n),
      .evt_i    (evt_i[g*REG_W +: REG_W]),
      .wr_en_i  (wr_en_i & sel_en[g]),
      .wr_data_i(wr_data_i),
      .clr_i    (rd_en_i & sel_stat[g]),
      .stat_o   (stat[g]),
      .en_o     (en[g]),
      .pend_o   (pend[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_stat[i]) rd_mux = stat[i];
      if (sel_en[i])   rd_mux = en[i];
    end
    in_range = (|sel_stat) | (|sel_en);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  irq_req_out #(.N(NREG)) u_req (
    .clk_i(clk_i), .rst_n_i(rst_n), .pend_i(pend), .irq_n_o(irq_n_o)
  );

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && !in_range) |=> (rd_data_o == '0));

  assert_read_pre_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && sel_stat[0]) |=> (rd_data_o == $past(stat[0])));
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic [7:0]  addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  // monitor: read strobe seen at an edge -> data compared at next negedge
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n=%b expected=%b", t, irq_n, e);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t,
                    input logic [15:0] ev = 16'h0);
    addr = a; rd_en = 1'b1; evt = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    cyc();
    rd_en = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    evt = m; cyc(); evt = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt = '0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (4) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    chk_irq(1'b1, "R4 reset");
    rd(8'h05, 8'h00, "R2 enable A reset");
    rd(8'h06, 8'h01, "R2 enable B reset");
    rd(8'h03, 8'h00, "R1 status A reset");
    rd(8'h04, 8'h00, "R1 status B reset");

    // disabled event latches, no request
    pulse(16'h0080);
    cyc(); cyc();
    chk_irq(1'b1, "R5 disabled event");
    rd(8'h03, 8'h80, "R1 latched");
    rd(8'h03, 8'h80, "R6 disabled bit kept");

    // enabling an old event raises the request
    wr(8'h05, 8'h80);
    chk_irq(1'b1, "R9 not same cycle");
    cyc();
    chk_irq(1'b0, "R9 enable raises");
    rd(8'h03, 8'h80, "R6 pre-clear value");
    cyc();
    chk_irq(1'b1, "R7 released");
    rd(8'h03, 8'h00, "R6 enabled bit cleared");

    // registered request, per-register clear
    pulse(16'h0100);
    chk_irq(1'b1, "R4 registered");
    cyc();
    chk_irq(1'b0, "R4 asserted");
    rd(8'h03, 8'h00, "R7 other register");
    cyc();
    chk_irq(1'b0, "R7 held by B");
    rd(8'h04, 8'h01, "R6 status B");
    cyc();
    chk_irq(1'b1, "R7 released B");

    // unused positions
    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h9B, "R3 enable mask");
    pulse(16'h00FF);
    rd(8'h03, 8'h9B, "R3 status mask");
    rd(8'h03, 8'h00, "R3 cleared");

    // partial clear
    wr(8'h05, 8'h01);
    pulse(16'h0011);
    rd(8'h03, 8'h11, "R6 both set");
    rd(8'h03, 8'h10, "R6 only enabled cleared");
    wr(8'h05, 8'h10);
    rd(8'h03, 8'h10, "R6 now enabled");
    rd(8'h03, 8'h00, "R6 cleared");

    // read-only status and unmapped addresses
    wr(8'h03, 8'hFF);
    rd(8'h03, 8'h00, "R1 write ignored");
    wr(8'h07, 8'hAA);
    rd(8'h07, 8'h00, "R10 read 07");
    rd(8'h02, 8'h00, "R10 read 02");
    rd(8'h05, 8'h10, "R10 enable A untouched");
    rd(8'h06, 8'h01, "R10 enable B untouched");

    // event colliding with clear
    wr(8'h06, 8'hFF);
    pulse(16'h0200);
    rd(8'h04, 8'h02, "R8 read with new event", 16'h0400);
    rd(8'h04, 8'h04, "R8 new event kept");
    rd(8'h04, 8'h00, "R8 cleared");
    pulse(16'h0800);
    rd(8'h04, 8'h08, "R8 same bit read", 16'h0800);
    rd(8'h04, 8'h08, "R8 same bit kept");
    rd(8'h04, 8'h00, "R8 same bit cleared");
    cyc();
    chk_irq(1'b1, "R8 idle");

    // both registers pending
    pulse(16'h8010);
    cyc();
    chk_irq(1'b0, "R7 both pending");
    rd(8'h03, 8'h10, "R7 A read");
    cyc();
    chk_irq(1'b0, "R7 B still pending");
    rd(8'h04, 8'h80, "R7 B read");
    cyc();
    chk_irq(1'b1, "R7 all clear");

    cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule